// File: doc/BRIEF.md
# Multi-channel DMA controller with suspend and resume

This block moves single words from a source address to a destination address for several channels. Each channel holds a source pointer, a destination pointer and a remaining-word count. Each accepted request moves exactly one word over a simple request/acknowledge memory bus: a read of the source, then a write of the destination. Channels are arbitrated by fixed priority, and the lowest index wins. Software programs the channels and the global control through a small register port.

Two global conditions stop all channels without losing progress. The first is clearing the master run bit. The second is a sticky abort flag raised by a non-maskable abort input. In both cases the word in flight is finished, no new word starts, and the bus is handed back to the processor. Each channel's pointers then name its next word, and its count gives the words still to move. A channel that is stopped this way does not report completion. While the abort flag is set, incoming requests are dropped, so a source must raise them again. The abort flag can be cleared only by a read that returns it as 1 followed by a control write with that bit 0. Each channel also reports whether it holds an accepted request that has not been serviced yet.

Register map, byte addresses: control at 0x00, with bit 0 the run bit and bit 1 the abort flag. Status at 0x04, with bits 3:0 the end flags and bits 11:8 the retained-request flags, bit 8+n for channel n. Channel n occupies the 16 bytes at 0x10·(n+1): source at +0x0, destination at +0x4, count at +0x8, and channel control at +0xC. In channel control, bit 0 is the channel enable and bits 2:1 select the request source: 0 means none, 1 means external, 2 means peripheral, and 3 means either.

Top module: `dma_halt_ctl`

## Requirements
- R1: When several enabled channels hold a request, have a non-zero count, the run bit is 1 and the abort flag is 0, the lowest-numbered channel is served first. Each grant moves one word: a read of the source address, then a write of that data to the destination address. A memory request stays asserted with a stable address until it is acknowledged.
- R2: Each completed word adds 4 to the channel's source and destination pointers and subtracts 1 from its count.
- R3: When a word brings the count to 0 while the run bit is 1 and the abort flag is 0, the channel's end flag (status bit n) is set and its enable (channel control bit 0) is cleared. Writing 1 to status bit n clears that end flag.
- R4: A pulse on the abort input sets the abort flag, control bit 1. The word in flight completes, and then no new word starts. `bus_owned` falls, the end flag stays 0, and the pointers and count hold the next word and the remaining count.
- R5: The abort flag clears only when a read of control returns it as 1 and a later control write has bit 1 equal to 0. A control write with bit 1 equal to 0 and no such prior read leaves the flag at 1.
- R6: While the abort flag is 1, requests from either source are not accepted, and the retained-request flag is not set.
- R7: With the run bit 0, no word starts, and accepted requests stay retained. Setting the run bit to 1 resumes each channel from its next word.
- R8: A channel's retained-request flag, status bit 8+n, becomes 1 when a request from its selected source is accepted. It returns to 0 when a word is served for that channel. A request accepted after the channel has ended stays retained.
- R9: Writing source select 0 to a channel clears its retained-request flag, and later requests on that channel are ignored.
- R10: After reset, every register reads 0 and `bus_owned` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, used for the abort-clear handshake |
| reg_addr | input | RAW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_ext | input | NCH | External request per channel, one pulse per request |
| req_per | input | NCH | Peripheral request per channel, one pulse per request |
| abort_in | input | 1 | Abort pulse that sets the sticky abort flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, completes the current access |
| bus_owned | output | 1 | 1 while the controller holds the bus |

## Verification
The memory-handshake property assumes the memory keeps its side of the protocol: the acknowledge arrives for the pending access only, and the controller's request does not need to fall early. The bench memory acknowledges one cycle after each request and never in two consecutive cycles. The properties also assume software does not rewrite a channel's pointers while that channel's word is in flight. The stimulus changes channel registers only when `bus_owned` has been low for several cycles. Request and abort pulses last one cycle and are driven between clock edges.

// File: rtl/dma_halt_ctl.sv
module dma_halt_ctl #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [NCH-1:0] req_ext,
  input  logic [NCH-1:0] req_per,
  input  logic           abort_in,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic           bus_owned
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [RAW-1:0] A_CTL = RAW'(0);
  localparam logic [RAW-1:0] A_STS = RAW'(4);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t            state;
  logic           men_q, halt_q, armed_q;
  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [1:0]     sel_q [NCH];
  logic [NCH-1:0] en_q, pend_q, end_q;
  logic [CHW-1:0] cur_q, gnt;
  logic [DW-1:0]  buf_q;

  logic [NCH-1:0] elig, acc, ch_hit;
  logic           start, done, fin_ok, ctl_wr, sts_wr, ctl_rd;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_hit[i] = reg_addr[RAW-1:4] == (RAW-4)'(i + 1);
      elig[i]   = en_q[i] & pend_q[i] & (cnt_q[i] != '0);
      acc[i]    = ~halt_q & ((sel_q[i][0] & req_ext[i]) | (sel_q[i][1] & req_per[i]));
    end
  end

  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) gnt = CHW'(i);
  end

  assign ctl_wr = reg_wr && reg_addr == A_CTL;
  assign ctl_rd = reg_rd && reg_addr == A_CTL;
  assign sts_wr = reg_wr && reg_addr == A_STS;
  assign start  = state == S_IDLE && men_q && !halt_q && |elig;
  assign done   = state == S_WR && mem_ack;
  assign fin_ok = men_q && !halt_q && !abort_in;

  assign mem_req   = state != S_IDLE;
  assign mem_we    = state == S_WR;
  assign mem_addr  = (state == S_WR) ? dst_q[cur_q] : src_q[cur_q];
  assign mem_wdata = buf_q;
  assign bus_owned = mem_req;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTL) begin
      reg_rdata[1:0] = {halt_q, men_q};
    end else if (reg_addr == A_STS) begin
      reg_rdata[NCH-1:0]  = end_q;
      reg_rdata[8 +: NCH] = pend_q;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (ch_hit[i])
          case (reg_addr[3:0])
            4'h0: reg_rdata = 32'(src_q[i]);
            4'h4: reg_rdata = 32'(dst_q[i]);
            4'h8: reg_rdata = 32'(cnt_q[i]);
            4'hC: reg_rdata[2:0] = {sel_q[i], en_q[i]};
            default: reg_rdata = '0;
          endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      men_q   <= 1'b0;
      halt_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin cur_q <= gnt; state <= S_RD; end
        S_RD:   if (mem_ack) begin buf_q <= mem_rdata; state <= S_WR; end
        S_WR:   if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (ctl_wr) begin
        men_q   <= reg_wdata[0];
        armed_q <= 1'b0;
        if (!reg_wdata[1] && armed_q) halt_q <= 1'b0;
      end
      if (ctl_rd && halt_q) armed_q <= 1'b1;
      if (abort_in) begin
        halt_q  <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      end_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        sel_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        logic svc, detach;
        svc    = done && cur_q == CHW'(i);
        detach = reg_wr && ch_hit[i] && reg_addr[3:0] == 4'hC && reg_wdata[2:1] == 2'b00;
        if (sts_wr && reg_wdata[i]) end_q[i] <= 1'b0;
        if (reg_wr && ch_hit[i])
          case (reg_addr[3:0])
            4'h0: src_q[i] <= AW'(reg_wdata);
            4'h4: dst_q[i] <= AW'(reg_wdata);
            4'h8: cnt_q[i] <= CW'(reg_wdata);
            4'hC: begin en_q[i] <= reg_wdata[0]; sel_q[i] <= reg_wdata[2:1]; end
            default: ;
          endcase
        pend_q[i] <= detach ? 1'b0 : ((pend_q[i] & ~svc) | acc[i]);
        if (svc) begin
          src_q[i] <= src_q[i] + AW'(4);
          dst_q[i] <= dst_q[i] + AW'(4);
          cnt_q[i] <= cnt_q[i] - CW'(1);
          if (cnt_q[i] == CW'(1) && fin_ok) begin
            end_q[i] <= 1'b1;
            en_q[i]  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_halt_ctl_chk.sv
module dma_halt_ctl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int RAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           men_q,
  input logic           halt_q,
  input logic           armed_q,
  input logic [NCH-1:0] end_q,
  input logic [NCH-1:0] pend_q,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]    reg_wdata,
  input logic           abort_in,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic           bus_owned
);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_end_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((end_q & ~$past(end_q)) != '0) |-> $past(men_q && !halt_q));

  assert_abort_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |=> halt_q);

  assert_no_start_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_owned && halt_q) |=> !bus_owned);

  assert_abort_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> $past(armed_q && reg_wr && reg_addr == '0 && !reg_wdata[1]));

  assert_no_accept_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> ((pend_q & ~$past(pend_q)) == '0));

  assert_no_start_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_owned && !men_q) |=> !bus_owned);
endmodule

bind dma_halt_ctl dma_halt_ctl_chk #(.NCH(NCH), .AW(AW), .RAW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .men_q(men_q), .halt_q(halt_q), .armed_q(armed_q),
  .end_q(end_q), .pend_q(pend_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .abort_in(abort_in), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .bus_owned(bus_owned)
);

// File: tb/dma_halt_ctl_tb_top.sv
module dma_halt_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] req_ext = '0, req_per = '0;
  logic abort_in = 0;
  logic mem_req, mem_we, mem_ack = 0, bus_owned;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [256];

  int nchk = 0, nfail = 0;
  logic [63:0] sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_halt_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_ext(req_ext), .req_per(req_per),
    .abort_in(abort_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .bus_owned(bus_owned)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ack) begin
      if (sb_q.size() == 0) chk("R1 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        logic [63:0] e;
        e = sb_q.pop_front();
        chk("R1 write address", mem_addr, e[63:32]);
        chk("R1 write data", mem_wdata, e[31:0]);
      end
    end
  end

  task automatic expect_word(logic [31:0] src, logic [31:0] dst);
    sb_q.push_back({dst, 32'hA500_0000 | {24'h0, src[9:2]}});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rchk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] e, input logic [NCH-1:0] p);
    @(negedge clk); req_ext = e; req_per = p;
    @(negedge clk); req_ext = '0; req_per = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = bus_owned ? 0 : quiet + 1;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10
    rchk("R10 control", 8'h00, 0);
    rchk("R10 status", 8'h04, 0);
    rchk("R10 count", 8'h18, 0);
    chk("R10 bus_owned", {31'b0, bus_owned}, 0);

    // R1 R2 R3: channel 0, three words
    wr(8'h10, 32'h100); wr(8'h14, 32'h200); wr(8'h18, 3); wr(8'h1C, 32'h3);
    wr(8'h00, 32'h1);
    for (int k = 0; k < 3; k++) begin
      expect_word(32'h100 + 4*k, 32'h200 + 4*k);
      pulse(4'b0001, 4'b0000);
      wait_idle();
    end
    rchk("R2 count ch0", 8'h18, 0);
    rchk("R2 source ch0", 8'h10, 32'h10C);
    rchk("R2 dest ch0", 8'h14, 32'h20C);
    rchk("R3 end flag ch0", 8'h04, 32'h1);
    rchk("R3 enable cleared ch0", 8'h1C, 32'h2);
    // R8 retained after end
    pulse(4'b0001, 4'b0000);
    rchk("R8 retained after end", 8'h04, 32'h101);
    wr(8'h04, 32'h1);
    rchk("R3 end flag cleared", 8'h04, 32'h100);
    wr(8'h1C, 32'h0);
    rchk("R9 detach clears retained ch0", 8'h04, 32'h0);

    // R1 priority, R7 run bit off holds requests
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h140); wr(8'h24, 32'h240); wr(8'h28, 2); wr(8'h2C, 32'h5);
    wr(8'h30, 32'h180); wr(8'h34, 32'h280); wr(8'h38, 2); wr(8'h3C, 32'h3);
    pulse(4'b0100, 4'b0010);
    repeat (6) @(negedge clk);
    chk("R7 no start with run off", {31'b0, bus_owned}, 0);
    rchk("R8 retained ch1 ch2", 8'h04, 32'h600);
    expect_word(32'h140, 32'h240);
    expect_word(32'h180, 32'h280);
    wr(8'h00, 32'h1);
    wait_idle();
    rchk("R1 count ch1", 8'h28, 1);
    rchk("R1 count ch2", 8'h38, 1);
    rchk("R8 retained cleared by service", 8'h04, 32'h0);

    // R4 abort mid-word
    wr(8'h40, 32'h300); wr(8'h44, 32'h380); wr(8'h48, 4); wr(8'h4C, 32'h5);
    expect_word(32'h300, 32'h380);
    pulse(4'b0000, 4'b1000);
    wait_idle();
    expect_word(32'h304, 32'h384);
    @(negedge clk); req_per = 4'b1000;
    @(negedge clk); req_per = '0;
    while (!bus_owned) @(negedge clk);
    abort_in = 1;
    @(negedge clk); abort_in = 0;
    wait_idle();
    chk("R4 bus released", {31'b0, bus_owned}, 0);
    rchk("R4 count holds remaining", 8'h48, 2);
    rchk("R4 source holds next", 8'h40, 32'h308);
    rchk("R4 dest holds next", 8'h44, 32'h388);
    rchk("R4 no end flag", 8'h04, 32'h0);
    // R6 requests dropped while aborted
    pulse(4'b0000, 4'b1010);
    repeat (4) @(negedge clk);
    rchk("R6 no retained while aborted", 8'h04, 32'h0);
    rchk("R6 ch1 count unchanged", 8'h28, 1);
    // R5 clear handshake
    wr(8'h00, 32'h1);
    rchk("R5 write without read keeps flag", 8'h00, 32'h3);
    wr(8'h00, 32'h1);
    rchk("R5 read then write clears", 8'h00, 32'h1);
    expect_word(32'h308, 32'h388);
    pulse(4'b0000, 4'b1000);
    wait_idle();
    rchk("R4 resumes after clear", 8'h48, 1);

    // R7 run bit off then on
    wr(8'h00, 32'h0);
    pulse(4'b0000, 4'b1000);
    repeat (4) @(negedge clk);
    rchk("R7 request retained", 8'h04, 32'h800);
    rchk("R7 count held", 8'h48, 1);
    expect_word(32'h30C, 32'h38C);
    wr(8'h00, 32'h1);
    wait_idle();
    rchk("R7 resumed count", 8'h48, 0);
    rchk("R3 end flag ch3", 8'h04, 32'h8);
    rchk("R3 enable cleared ch3", 8'h4C, 32'h4);

    // R9 detach
    wr(8'h00, 32'h0);
    pulse(4'b0100, 4'b0000);
    rchk("R8 retained ch2", 8'h04, 32'h408);
    wr(8'h3C, 32'h1);
    rchk("R9 detach clears ch2", 8'h04, 32'h008);
    pulse(4'b0100, 4'b0000);
    rchk("R9 detached ignores request", 8'h04, 32'h008);
    wr(8'h00, 32'h1);
    wait_idle();
    rchk("R9 no transfer after detach", 8'h38, 1);
    wr(8'h04, 32'h8);
    rchk("R3 end flag ch3 cleared", 8'h04, 32'h0);

    chk("R1 scoreboard drained", sb_q.size(), 0);
    finish_up();
  end
endmodule